// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End

This block is a synchronous, cycle-level model of the write-command side of a byte-wide parallel NOR flash. A host drives active-low chip enable, write enable and output enable strobes together with an 18-bit address and an 8-bit data bus. Writes are decoded as multi-cycle, unlock-protected command sequences. These sequences cover three operations: byte program, sector erase and chip erase.

Once a command completes, the block enters a busy window whose length is a parameterised number of clock cycles. During that window all further bus writes are dropped, and reads return a status byte instead of array contents. The status byte carries a polarity flag on bit 7 and a toggling flag on bit 6. When the window ends, the operation is applied to a small on-chip byte array, and reads return stored data again.

The array is deliberately small. A byte is located by the low sector-select address bits starting at bit 12, combined with the low offset bits of the address. Other address bits alias.

Top module: `nfc_flash_front`

## Requirements
- R1: After reset every array byte reads FFh. When ce_n and oe_n are both low, dq_en is 1 and dq_out shows the addressed byte (or status while busy). Otherwise dq_en is 0.
- R2: A bus write is taken once per strobe pulse, in the first cycle where ce_n and we_n are both low. Address and data are sampled in that same cycle.
- R3: The program sequence is AAh@05555h, 55h@02AAAh, A0h@05555h, followed by a fourth write carrying target address and data. It leaves the target byte equal to its old value AND the written data.
- R4: The sector erase sequence is AAh@05555h, 55h@02AAAh, 80h@05555h, AAh@05555h, 55h@02AAAh, then 30h at any address. It sets to FFh every byte whose sector field (address bits 12 and up) matches that address, and leaves other sectors untouched.
- R5: The chip erase sequence is the same five setup writes followed by 10h@05555h. It sets every byte to FFh.
- R6: A write that does not match the next expected cycle returns the decoder to idle, so no operation starts.
- R7: The busy window lasts exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles after the launching write. A read in the last busy cycle returns status, and a read in the next cycle returns the updated byte.
- R8: Every write taken while busy is ignored, including one that lands in the completion cycle.
- R9: While a program is busy, bit 7 of a read is the complement of bit 7 of the data being programmed. While an erase is busy, bit 7 reads 0.
- R10: While busy, bit 6 changes between successive reads, and bits 5..0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 18 | Byte address |
| dq_in | input | 8 | Write data from host |
| dq_out | output | 8 | Read data or status |
| dq_en | output | 1 | Output drive enable; 0 means bus released |

## Verification
Two events can coincide in one cycle: the busy timer finishing, and a new bus write or read arriving. The bench launches a program and immediately issues a second full program sequence, timed so that its fourth write falls exactly on the completion cycle. The expected result is that the second target byte still reads FFh, because every one of its writes met a busy block. A held read that spans the last busy cycle and the first idle cycle is checked for status first and stored data next.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E1, ST_E2, ST_E3
    } cmd_st_e;

    typedef enum logic [1:0] {
        OP_NONE, OP_PROG, OP_SECT, OP_CHIP
    } op_e;

    localparam logic [17:0] ADR_KEY_A = 18'h05555;
    localparam logic [17:0] ADR_KEY_B = 18'h02AAA;
    localparam logic [7:0]  DAT_KEY_A = 8'hAA;
    localparam logic [7:0]  DAT_KEY_B = 8'h55;
    localparam logic [7:0]  DAT_PROG  = 8'hA0;
    localparam logic [7:0]  DAT_ESET  = 8'h80;
    localparam logic [7:0]  DAT_SECT  = 8'h30;
    localparam logic [7:0]  DAT_CHIP  = 8'h10;

    typedef struct packed {
        cmd_st_e st;
    } unlock_s;
endpackage

// File: rtl/nfc_unlock.sv
module nfc_unlock
    import nfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [17:0] addr_i,
    input  logic [7:0]  data_i,
    input  logic        busy_i,
    output logic        launch_o,
    output op_e         op_o
);
    unlock_s q, d;

    always_comb begin
        d        = q;
        launch_o = 1'b0;
        op_o     = OP_NONE;
        if (wr_i && !busy_i) begin
            d.st = ST_IDLE;
            case (q.st)
                ST_IDLE: if (addr_i == ADR_KEY_A && data_i == DAT_KEY_A) d.st = ST_U1;
                ST_U1:   if (addr_i == ADR_KEY_B && data_i == DAT_KEY_B) d.st = ST_U2;
                ST_U2: begin
                    if (addr_i == ADR_KEY_A && data_i == DAT_PROG) d.st = ST_PGM;
                    if (addr_i == ADR_KEY_A && data_i == DAT_ESET) d.st = ST_E1;
                end
                ST_PGM: begin
                    launch_o = 1'b1;
                    op_o     = OP_PROG;
                end
                ST_E1: if (addr_i == ADR_KEY_A && data_i == DAT_KEY_A) d.st = ST_E2;
                ST_E2: if (addr_i == ADR_KEY_B && data_i == DAT_KEY_B) d.st = ST_E3;
                ST_E3: begin
                    if (data_i == DAT_SECT) begin
                        launch_o = 1'b1;
                        op_o     = OP_SECT;
                    end else if (data_i == DAT_CHIP && addr_i == ADR_KEY_A) begin
                        launch_o = 1'b1;
                        op_o     = OP_CHIP;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE};
        else        q <= d;
    end

    // R8: the decoder never leaves idle while an operation runs
    assert_idle_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (q.st == ST_IDLE));
endmodule

// File: rtl/nfc_busy.sv
module nfc_busy
    import nfc_pkg::*;
#(
    parameter int PROG_CYC = 8,
    parameter int SECT_CYC = 40,
    parameter int CHIP_CYC = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch_i,
    input  op_e         op_i,
    input  logic [17:0] addr_i,
    input  logic [7:0]  data_i,
    output logic        busy_o,
    output logic        done_o,
    output op_e         op_o,
    output logic [17:0] addr_o,
    output logic [7:0]  data_o
);
    localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_C = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        op_e              op;
        logic [17:0]      addr;
        logic [7:0]       data;
    } tmr_s;

    tmr_s q, d;

    always_comb begin
        d      = q;
        done_o = q.busy && (q.cnt == '0);
        if (q.busy) begin
            if (q.cnt == '0) d.busy = 1'b0;
            else             d.cnt  = q.cnt - 1'b1;
        end else if (launch_i) begin
            d.busy = 1'b1;
            d.op   = op_i;
            d.addr = addr_i;
            d.data = data_i;
            case (op_i)
                OP_PROG: d.cnt = CNT_W'(PROG_CYC - 1);
                OP_SECT: d.cnt = CNT_W'(SECT_CYC - 1);
                default: d.cnt = CNT_W'(CHIP_CYC - 1);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{busy: 1'b0, cnt: '0, op: OP_NONE, addr: '0, data: '0};
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign op_o   = q.op;
    assign addr_o = q.addr;
    assign data_o = q.data;

    // R7: busy persists until the count is exhausted
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != '0) |=> q.busy);
    // R8: a busy window only opens on a decoded command
    assert_start_from_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(launch_i));
endmodule

// File: rtl/nfc_array.sv
module nfc_array
    import nfc_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int OFF_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy_i,
    input  logic        done_i,
    input  op_e         op_i,
    input  logic [17:0] addr_i,
    input  logic [7:0]  data_i,
    input  logic [17:0] rd_addr_i,
    output logic [7:0]  rd_data_o
);
    localparam int IDX_W = SEL_W + OFF_W;
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
    } arr_s;

    arr_s q, d;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [SEL_W-1:0] sec;

    assign wr_idx = {addr_i[12 +: SEL_W], addr_i[OFF_W-1:0]};
    assign rd_idx = {rd_addr_i[12 +: SEL_W], rd_addr_i[OFF_W-1:0]};
    assign sec    = addr_i[12 +: SEL_W];

    always_comb begin
        d = q;
        if (done_i) begin
            case (op_i)
                OP_PROG: d.mem[wr_idx] = q.mem[wr_idx] & data_i;
                OP_SECT: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if ((i >> OFF_W) == int'(sec)) d.mem[i] = 8'hFF;
                    end
                end
                OP_CHIP: d.mem = '1;
                default: d = q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign rd_data_o = q.mem[rd_idx];

    // R8: cells hold still for the whole busy window until completion
    assert_cells_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !done_i) |=> $stable(q));
endmodule

// File: rtl/nfc_flash_front.sv
module nfc_flash_front
    import nfc_pkg::*;
#(
    parameter int PROG_CYC = 8,
    parameter int SECT_CYC = 40,
    parameter int CHIP_CYC = 64,
    parameter int SEL_W    = 2,
    parameter int OFF_W    = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [17:0] addr,
    input  logic [7:0]  dq_in,
    output logic [7:0]  dq_out,
    output logic        dq_en
);
    typedef struct packed {
        logic wr_act;
        logic rd_act;
        logic tog;
    } bus_s;

    bus_s q, d;
    logic        wr_now, wr_pulse, rd_now;
    logic        launch, busy, done;
    op_e         cmd_op, run_op;
    logic [17:0] run_addr;
    logic [7:0]  run_data, cell_data;

    assign wr_now   = !ce_n && !we_n;
    assign wr_pulse = wr_now && !q.wr_act;
    assign rd_now   = !ce_n && !oe_n;

    nfc_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_pulse), .addr_i(addr), .data_i(dq_in),
        .busy_i(busy), .launch_o(launch), .op_o(cmd_op)
    );

    nfc_busy #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .op_i(cmd_op), .addr_i(addr),
        .data_i(dq_in), .busy_o(busy), .done_o(done), .op_o(run_op),
        .addr_o(run_addr), .data_o(run_data)
    );

    nfc_array #(.SEL_W(SEL_W), .OFF_W(OFF_W)) u_array (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .done_i(done), .op_i(run_op),
        .addr_i(run_addr), .data_i(run_data), .rd_addr_i(addr), .rd_data_o(cell_data)
    );

    always_comb begin
        d        = q;
        d.wr_act = wr_now;
        d.rd_act = rd_now;
        if (busy && q.rd_act && !rd_now) d.tog = ~q.tog;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{wr_act: 1'b0, rd_act: 1'b0, tog: 1'b0};
        else        q <= d;
    end

    always_comb begin
        if (busy) dq_out = {(run_op == OP_PROG) ? ~run_data[7] : 1'b0, q.tog, 6'b0};
        else      dq_out = cell_data;
    end

    assign dq_en = rd_now;

    // R1: output enable high always releases the bus
    assert_bus_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_en);
endmodule

// File: tb/nfc_flash_front_test.sv
module nfc_flash_front_test;
    localparam int PROG_CYC = 8;
    localparam int SECT_CYC = 40;
    localparam int CHIP_CYC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_en;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    nfc_flash_front #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_en(dq_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at a negedge one cycle after the sampling edge
    task automatic wr(input logic [17:0] a, input logic [7:0] v);
        ce_n = 1'b0; we_n = 1'b0; addr = a; dq_in = v;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [17:0] a, output logic [7:0] v);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1 v = dq_out;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic seq_prog(input logic [17:0] a, input logic [7:0] v);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(a, v);
    endtask

    task automatic seq_erase(input logic [17:0] a, input logic [7:0] c);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h80);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(a, c);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 bus idle dq_en", {7'b0, dq_en}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        check("R1 ce high releases bus", {7'b0, dq_en}, 8'h00);
        oe_n = 1'b1; ce_n = 1'b0; #1;
        check("R1 oe high releases bus", {7'b0, dq_en}, 8'h00);
        ce_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = 18'h00003; #1;
        check("R1 read drives bus", {7'b0, dq_en}, 8'h01);
        check("R1 reset contents", dq_out, 8'hFF);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; @(negedge clk);
    endtask

    task automatic t_program();
        logic [7:0] v, s1, s2;
        seq_prog(18'h00003, 8'h5A);
        rd(18'h00003, s1);
        check("R9 program dq7 complement", {7'b0, s1[7]}, 8'h01);
        check("R10 low status bits zero", {2'b0, s1[5:0]}, 8'h00);
        rd(18'h00003, s2);
        check("R10 dq6 toggles", {7'b0, s2[6]}, {7'b0, ~s1[6]});
        idle(PROG_CYC - 1 - 5);
        ce_n = 1'b0; oe_n = 1'b0; addr = 18'h00003;
        #1 v = dq_out;
        check("R7 last busy cycle shows status", v & 8'h80, 8'h80);
        @(negedge clk);
        #1 v = dq_out;
        check("R7 first idle cycle shows data", v, 8'h5A);
        ce_n = 1'b1; oe_n = 1'b1;
        idle(1);
        seq_prog(18'h00003, 8'h0F);
        idle(PROG_CYC + 2);
        rd(18'h00003, v);
        check("R3 program ANDs old value", v, 8'h0A);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        seq_prog(18'h00005, 8'h00);
        // second sequence: its fourth write lands on the completion cycle
        seq_prog(18'h00006, 8'h00);
        idle(PROG_CYC + 2);
        rd(18'h00006, v);
        check("R8 writes while busy ignored", v, 8'hFF);
        rd(18'h00005, v);
        check("R3 first program applied", v, 8'h00);
    endtask

    task automatic t_bad_unlock();
        logic [7:0] v;
        wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00007, 8'h00);
        idle(PROG_CYC + 2);
        rd(18'h00007, v);
        check("R6 wrong address aborts", v, 8'hFF);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90); wr(18'h00007, 8'h00);
        idle(PROG_CYC + 2);
        rd(18'h00007, v);
        check("R6 wrong command aborts", v, 8'hFF);
    endtask

    task automatic t_strobe_once();
        logic [7:0] v;
        // a long strobe must count as one write: AA held two cycles then 55
        ce_n = 1'b0; we_n = 1'b0; addr = 18'h05555; dq_in = 8'hAA;
        idle(2);
        ce_n = 1'b1; we_n = 1'b1; idle(1);
        wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00001, 8'h3C);
        idle(PROG_CYC + 2);
        rd(18'h00001, v);
        check("R2 held strobe is one write", v, 8'h3C);
    endtask

    task automatic t_sector();
        logic [7:0] v, s1, s2;
        seq_prog(18'h01003, 8'h11); idle(PROG_CYC + 2);
        seq_prog(18'h02004, 8'h22); idle(PROG_CYC + 2);
        seq_erase(18'h01000, 8'h30);
        rd(18'h01003, s1);
        check("R9 erase dq7 zero", {7'b0, s1[7]}, 8'h00);
        rd(18'h01003, s2);
        check("R10 dq6 toggles in erase", {7'b0, s2[6]}, {7'b0, ~s1[6]});
        idle(SECT_CYC + 2);
        rd(18'h01003, v);
        check("R4 selected sector erased", v, 8'hFF);
        rd(18'h02004, v);
        check("R4 other sector kept", v, 8'h22);
    endtask

    task automatic t_chip();
        logic [7:0] v;
        seq_erase(18'h05555, 8'h10);
        rd(18'h00003, v);
        check("R9 chip erase dq7 zero", {7'b0, v[7]}, 8'h00);
        idle(CHIP_CYC + 2);
        rd(18'h02004, v);
        check("R5 chip erase sector 2", v, 8'hFF);
        rd(18'h00005, v);
        check("R5 chip erase sector 0", v, 8'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_program();
        t_busy_ignore();
        t_bad_unlock();
        t_strobe_once();
        t_sector();
        t_chip();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule